// File: doc/BRIEF.md
# Video Payload Identifier Word Writer

This block assembles the four-byte payload identifier word that a serial video transmitter places in each of its data streams, and then delivers that word as a sequence of slot writes into a payload bank. The word is built from the current link configuration: link mode, fractional-rate flag, scan structure (interlaced, double-scan), horizontal active width, total line count and input colour sampling. The byte-1 code and the two candidate byte-2 base codes, one for integer and one for fractional frame rates, come in on pins from an external mode table.

A one-cycle `start_i` pulse samples the whole configuration, computes the base word and begins issuing writes. One write goes out per slot in ascending slot order, to the luma bank and, when chroma insertion is enabled, to the chroma bank as well. A one-cycle `clear_i` pulse instead writes zero to every slot, which is how the payload bank is emptied when the link is disabled. Writes leave on a valid/ready channel. A write stays presented, unchanged, until the bank accepts it with `wr_ready_i` high, so the bank may stall the block for any number of cycles. `done_o` pulses once after the final write is accepted.

Top module: `vpid_writer`

## Requirements
- R1: Every non-zero word carries 0x01 in bits 28:24 (byte 4, bits 31:24, holds 0x01 before any channel stamp). Byte 1 (bits 7:0) equals `b1_code_i`. The byte-2 base (bits 15:8) is `b2_code_frac_i` when `frac_i` is 1 and `b2_code_int_i` otherwise.
- R2: Byte 3 (bits 23:16) starts at 0x00. Its bit 6 (word bit 22) is set when `h_active_i` equals 2048 or 4096. Its bits 1:0 (word bits 17:16) are set to 2'b11 when `yuv420_i` is 1.
- R3: Byte-2 bit 6 (word bit 14, progressive picture) is set when `link_mode_i` is 3 (dual-link 3G level B), when `dblscan_i` is 1, or when `interlaced_i` is 0.
- R4: Byte-2 bit 7 (word bit 15, progressive transport) is set only when `interlaced_i` is 0 and `v_total_i` is at least 1125. A total of 1124 leaves the bit clear.
- R5: A start produces writes for slots 0 up to N-1 in ascending order, where N is the stream count divided by two. `strm_sel_i` encodes the stream count as 0=2, 1=4, 2=8 and 3=8, which gives N = 1, 2, 4 and 4.
- R6: When `link_mode_i` is 3, the value slot×2 is ORed into bits 31:29 of that slot's word. In all other link modes these bits are left as in R1.
- R7: With `chroma_en_i` set at start, each slot is written to bank 0 (luma, `wr_bank_o`=0) and then to bank 1 (chroma) with the same word, before the next slot is written. With it clear, only bank 0 is written.
- R8: A clear writes zero to all 8 slots of bank 0, and also to bank 1 when `chroma_en_i` is set, using the order of R7. The data is zero in every link mode. A clear in the same cycle as a start wins, and the start is dropped.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_data_o`, `wr_slot_o` and `wr_bank_o` hold their values. The sequence advances only on an accepted write.
- R10: After reset `busy_o`, `wr_valid_o` and `done_o` are low. `done_o` is high for exactly the one cycle after the final write is accepted. After that cycle `busy_o` is low.
- R11: A start or clear that arrives while `busy_o` is high is ignored, and so are changes to the configuration inputs after the start was taken. The written words and their count depend only on the values sampled with the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse: build word and write all slots |
| clear_i | input | 1 | Pulse: write zero to all slots |
| link_mode_i | input | 3 | 0 HD, 1 SD, 2 3G-A, 3 3G-B, 4 6G, 5 12G |
| frac_i | input | 1 | Fractional frame rate |
| interlaced_i | input | 1 | Interlaced scan |
| dblscan_i | input | 1 | Double-scan (segmented) picture |
| h_active_i | input | 13 | Active pixels per line |
| v_total_i | input | 12 | Total lines per frame |
| yuv420_i | input | 1 | Input is 4:2:0 |
| b1_code_i | input | 8 | Byte-1 code |
| b2_code_int_i | input | 8 | Byte-2 base, integer rate |
| b2_code_frac_i | input | 8 | Byte-2 base, fractional rate |
| strm_sel_i | input | 2 | Stream count select |
| chroma_en_i | input | 1 | Also write chroma bank |
| wr_valid_o | output | 1 | Write presented |
| wr_ready_i | input | 1 | Bank accepts write |
| wr_bank_o | output | 1 | 0 luma, 1 chroma |
| wr_slot_o | output | 3 | Slot index |
| wr_data_o | output | 32 | Word to write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished pulse |

## Verification
The configurations in the bench table cover the cases the rules must separate. A progressive 1125-line format against an interlaced one shows whether bit 7 is tied to scan type. Progressive at 750 and at 1124 lines shows whether the threshold is inclusive. Interlaced with double-scan and interlaced 3G-B isolate the two other sources of bit 6. Widths of 2048, 4096, 1920 and 3840 show whether the byte-3 width flag is an exact match. Each stream select with and without chroma shows the write count and the luma/chroma interleave. In a 3G-B run with eight streams, a stamp computed from something other than slot×2 gives a different word. Clear runs in 3G-B mode and a clear colliding with a start show that zero data wins over stamping. A run stalled by the ready signal and a run disturbed by a mid-sequence start and changed configuration show that the output holds under a stall and that a second start changes nothing.

// File: rtl/vpid_pkg.sv
package vpid_pkg;

  typedef enum logic [2:0] {
    LM_HD  = 3'd0,
    LM_SD  = 3'd1,
    LM_3GA = 3'd2,
    LM_3GB = 3'd3,
    LM_6G  = 3'd4,
    LM_12G = 3'd5
  } link_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [7:0] b4;
    logic [7:0] b3;
    logic [7:0] b2;
    logic [7:0] b1;
  } vpid_word_t;

  localparam logic [7:0] BYTE4_CODE    = 8'h01;
  localparam int         B2_PROG_PIC   = 6;
  localparam int         B2_PROG_TRANS = 7;
  localparam int         B3_WIDE       = 6;
  localparam logic [1:0] B3_SUB420     = 2'b11;

endpackage

// File: rtl/vpid_word_calc.sv
module vpid_word_calc
  import vpid_pkg::*;
#(
  parameter int H_W              = 13,
  parameter int V_W              = 12,
  parameter int PROG_TRANS_LINES = 1125
) (
  input  logic [2:0]     link_mode_i,
  input  logic           frac_i,
  input  logic           interlaced_i,
  input  logic           dblscan_i,
  input  logic [H_W-1:0] h_active_i,
  input  logic [V_W-1:0] v_total_i,
  input  logic           yuv420_i,
  input  logic [7:0]     b1_code_i,
  input  logic [7:0]     b2_code_int_i,
  input  logic [7:0]     b2_code_frac_i,
  output logic [31:0]    word_o,
  output logic           is_3gb_o
);

  localparam logic [H_W-1:0] WIDE_A   = H_W'(2048);
  localparam logic [H_W-1:0] WIDE_B   = H_W'(4096);
  localparam logic [V_W-1:0] TRANS_MIN = V_W'(PROG_TRANS_LINES);

  vpid_word_t w;
  logic       progressive;
  logic       wide;

  always_comb begin
    is_3gb_o    = (link_mode_e'(link_mode_i) == LM_3GB);
    progressive = !interlaced_i;
    wide        = (h_active_i == WIDE_A) || (h_active_i == WIDE_B);

    w.b4 = BYTE4_CODE;
    w.b1 = b1_code_i;

    w.b3 = 8'h00;
    if (wide)     w.b3[B3_WIDE] = 1'b1;
    if (yuv420_i) w.b3[1:0]     = B3_SUB420;

    w.b2 = frac_i ? b2_code_frac_i : b2_code_int_i;
    if (is_3gb_o || dblscan_i || progressive)
      w.b2[B2_PROG_PIC] = 1'b1;
    if (progressive && (v_total_i >= TRANS_MIN))
      w.b2[B2_PROG_TRANS] = 1'b1;

    word_o = w;
  end

endmodule

// File: rtl/vpid_seq.sv
module vpid_seq
  import vpid_pkg::*;
#(
  parameter int MAX_STREAMS = 8,
  parameter int SEL_W       = 2,
  localparam int SLOT_W     = $clog2(MAX_STREAMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              chroma_en_i,
  input  logic [SEL_W-1:0]  strm_sel_i,
  input  logic              wr_ready_i,
  output logic              wr_valid_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              bank_o,
  output logic              zero_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              take_start_o
);

  localparam int HALF    = MAX_STREAMS / 2;
  localparam int SEL_NUM = 1 << SEL_W;

  seq_state_e        st_q;
  logic [SLOT_W-1:0] idx_q;
  logic [SLOT_W-1:0] last_q;
  logic              bank_q;
  logic              zero_q;
  logic              chroma_q;
  logic [SLOT_W-1:0] run_last;
  logic              take_clear;
  logic              accept;
  logic              slot_end;

  // Last slot index for a start: 2^sel writes, capped at half the streams.
  always_comb begin
    run_last = SLOT_W'(HALF - 1);
    for (int s = 0; s < SEL_NUM; s++) begin
      if ((strm_sel_i == SEL_W'(s)) && ((1 << s) < HALF))
        run_last = SLOT_W'((1 << s) - 1);
    end
  end

  assign take_clear   = (st_q == SQ_IDLE) && clear_i;
  assign take_start_o = (st_q == SQ_IDLE) && start_i && !clear_i;
  assign accept       = (st_q == SQ_RUN) && wr_ready_i;
  assign slot_end     = !chroma_q || bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      bank_q   <= 1'b0;
      zero_q   <= 1'b0;
      chroma_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (take_clear || take_start_o) begin
            st_q     <= SQ_RUN;
            idx_q    <= '0;
            bank_q   <= 1'b0;
            chroma_q <= chroma_en_i;
            zero_q   <= take_clear;
            last_q   <= take_clear ? SLOT_W'(MAX_STREAMS - 1) : run_last;
          end
        end
        SQ_RUN: begin
          if (accept) begin
            if (!slot_end) begin
              bank_q <= 1'b1;
            end else begin
              bank_q <= 1'b0;
              if (idx_q == last_q) st_q <= SQ_DONE;
              else                 idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (st_q == SQ_RUN);
  assign busy_o     = (st_q != SQ_IDLE);
  assign done_o     = (st_q == SQ_DONE);
  assign slot_o     = idx_q;
  assign bank_o     = bank_q;
  assign zero_o     = zero_q;

endmodule

// File: rtl/vpid_stamp.sv
module vpid_stamp #(
  parameter int SLOT_W    = 3,
  parameter int STAMP_LSB = 29
) (
  input  logic [31:0]       base_i,
  input  logic              is_3gb_i,
  input  logic              zero_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [31:0]       word_o
);

  localparam int STAMP_W = 32 - STAMP_LSB;

  logic [STAMP_W-1:0] chan;
  logic [31:0]        stamp;

  always_comb begin
    chan   = STAMP_W'({slot_i, 1'b0});
    stamp  = is_3gb_i ? {chan, {STAMP_LSB{1'b0}}} : 32'h0;
    word_o = zero_i ? 32'h0 : (base_i | stamp);
  end

endmodule

// File: rtl/vpid_writer.sv
module vpid_writer
  import vpid_pkg::*;
#(
  parameter int MAX_STREAMS      = 8,
  parameter int SEL_W            = 2,
  parameter int H_W              = 13,
  parameter int V_W              = 12,
  parameter int STAMP_LSB        = 29,
  parameter int PROG_TRANS_LINES = 1125,
  localparam int SLOT_W          = $clog2(MAX_STREAMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [2:0]        link_mode_i,
  input  logic              frac_i,
  input  logic              interlaced_i,
  input  logic              dblscan_i,
  input  logic [H_W-1:0]    h_active_i,
  input  logic [V_W-1:0]    v_total_i,
  input  logic              yuv420_i,
  input  logic [7:0]        b1_code_i,
  input  logic [7:0]        b2_code_int_i,
  input  logic [7:0]        b2_code_frac_i,
  input  logic [SEL_W-1:0]  strm_sel_i,
  input  logic              chroma_en_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              wr_bank_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [31:0]       wr_data_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [31:0]       calc_word;
  logic              calc_3gb;
  logic [31:0]       base_q;
  logic              is_3gb_q;
  logic              take_start;
  logic              zero;
  logic [SLOT_W-1:0] slot;

  vpid_word_calc #(
    .H_W              (H_W),
    .V_W              (V_W),
    .PROG_TRANS_LINES (PROG_TRANS_LINES)
  ) u_calc (
    .link_mode_i    (link_mode_i),
    .frac_i         (frac_i),
    .interlaced_i   (interlaced_i),
    .dblscan_i      (dblscan_i),
    .h_active_i     (h_active_i),
    .v_total_i      (v_total_i),
    .yuv420_i       (yuv420_i),
    .b1_code_i      (b1_code_i),
    .b2_code_int_i  (b2_code_int_i),
    .b2_code_frac_i (b2_code_frac_i),
    .word_o         (calc_word),
    .is_3gb_o       (calc_3gb)
  );

  vpid_seq #(
    .MAX_STREAMS (MAX_STREAMS),
    .SEL_W       (SEL_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .clear_i      (clear_i),
    .chroma_en_i  (chroma_en_i),
    .strm_sel_i   (strm_sel_i),
    .wr_ready_i   (wr_ready_i),
    .wr_valid_o   (wr_valid_o),
    .slot_o       (slot),
    .bank_o       (wr_bank_o),
    .zero_o       (zero),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .take_start_o (take_start)
  );

  // Configuration is sampled once, with the accepted start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      is_3gb_q <= 1'b0;
    end else if (take_start) begin
      base_q   <= calc_word;
      is_3gb_q <= calc_3gb;
    end
  end

  vpid_stamp #(
    .SLOT_W    (SLOT_W),
    .STAMP_LSB (STAMP_LSB)
  ) u_stamp (
    .base_i   (base_q),
    .is_3gb_i (is_3gb_q),
    .zero_i   (zero),
    .slot_i   (slot),
    .word_o   (wr_data_o)
  );

  assign wr_slot_o = slot;

endmodule

// File: rtl/vpid_writer_chk.sv
module vpid_writer_chk #(
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              clear_i,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic              wr_bank_o,
  input logic [SLOT_W-1:0] wr_slot_o,
  input logic [31:0]       wr_data_o,
  input logic              busy_o,
  input logic              done_o
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o)
      && $stable(wr_slot_o) && $stable(wr_bank_o));

  assert_valid_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

  assert_done_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_valid_o && wr_ready_i));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  assert_byte4_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && (wr_data_o != 32'h0) |-> wr_data_o[28:24] == 5'h01);

  assert_busy_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i || clear_i));

endmodule

bind vpid_writer vpid_writer_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .clear_i    (clear_i),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_bank_o  (wr_bank_o),
  .wr_slot_o  (wr_slot_o),
  .wr_data_o  (wr_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_vpid_writer.sv
module tb_vpid_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [2:0]  link_mode_i = '0;
  logic        frac_i = 1'b0;
  logic        interlaced_i = 1'b0;
  logic        dblscan_i = 1'b0;
  logic [12:0] h_active_i = '0;
  logic [11:0] v_total_i = '0;
  logic        yuv420_i = 1'b0;
  logic [7:0]  b1_code_i = '0;
  logic [7:0]  b2_code_int_i = '0;
  logic [7:0]  b2_code_frac_i = '0;
  logic [1:0]  strm_sel_i = '0;
  logic        chroma_en_i = 1'b0;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b1;
  logic        wr_bank_o;
  logic [2:0]  wr_slot_o;
  logic [31:0] wr_data_o;
  logic        busy_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vpid_writer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .link_mode_i(link_mode_i), .frac_i(frac_i), .interlaced_i(interlaced_i),
    .dblscan_i(dblscan_i), .h_active_i(h_active_i), .v_total_i(v_total_i),
    .yuv420_i(yuv420_i), .b1_code_i(b1_code_i), .b2_code_int_i(b2_code_int_i),
    .b2_code_frac_i(b2_code_frac_i), .strm_sel_i(strm_sel_i),
    .chroma_en_i(chroma_en_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_bank_o(wr_bank_o), .wr_slot_o(wr_slot_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        frac;
    logic        il;
    logic        ds;
    logic [12:0] hact;
    logic [11:0] vtot;
    logic        y420;
    logic [7:0]  b1;
    logic [7:0]  b2i;
    logic [7:0]  b2f;
    logic [1:0]  sel;
    logic        ch;
    logic [31:0] base;
  } vec_t;

  // R1..R7: configuration and the expected base word (before any stamp).
  localparam vec_t VECS [7] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 13'd1920, 12'd1125, 1'b0, 8'h85, 8'h07, 8'h06, 2'd0, 1'b0, 32'h0100C785},
    '{3'd0, 1'b1, 1'b1, 1'b0, 13'd1920, 12'd1125, 1'b1, 8'h85, 8'h07, 8'h06, 2'd1, 1'b1, 32'h01030685},
    '{3'd3, 1'b0, 1'b1, 1'b0, 13'd2048, 12'd1125, 1'b0, 8'h8A, 8'h0A, 8'h0B, 2'd1, 1'b0, 32'h01404A8A},
    '{3'd2, 1'b0, 1'b0, 1'b0, 13'd1280, 12'd750,  1'b0, 8'h89, 8'h0B, 8'h0C, 2'd2, 1'b0, 32'h01004B89},
    '{3'd0, 1'b0, 1'b1, 1'b1, 13'd4096, 12'd1125, 1'b1, 8'h01, 8'h05, 8'h04, 2'd0, 1'b1, 32'h01434501},
    '{3'd5, 1'b0, 1'b0, 1'b0, 13'd3840, 12'd1124, 1'b0, 8'hCE, 8'h08, 8'h09, 2'd2, 1'b1, 32'h010048CE},
    '{3'd3, 1'b1, 1'b0, 1'b0, 13'd1920, 12'd1125, 1'b0, 8'h8A, 8'h0A, 8'h06, 2'd3, 1'b1, 32'h0100C68A}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    link_mode_i    = v.mode;
    frac_i         = v.frac;
    interlaced_i   = v.il;
    dblscan_i      = v.ds;
    h_active_i     = v.hact;
    v_total_i      = v.vtot;
    yuv420_i       = v.y420;
    b1_code_i      = v.b1;
    b2_code_int_i  = v.b2i;
    b2_code_frac_i = v.b2f;
    strm_sel_i     = v.sel;
    chroma_en_i    = v.ch;
  endtask

  // Called at the negedge after the pulse edge; collects and checks writes.
  task automatic collect(input logic [31:0] base, input bit stamp,
                         input int nslots, input bit ch, input bit stall,
                         input bit disturb, input string req);
    int total = nslots * (ch ? 2 : 1);
    int k = 0;
    int guard = 0;
    bit stalled = 1'b0;
    logic [31:0] pd = '0;
    logic [2:0]  ps = '0;
    logic        pb = 1'b0;
    while (k < total && guard < 2000) begin
      wr_ready_i = stall ? guard[0] : 1'b1;
      if (disturb && guard == 2) begin
        start_i = 1'b1; link_mode_i = 3'd3; b1_code_i = 8'hFF; strm_sel_i = 2'd0;
      end
      if (disturb && guard == 3) start_i = 1'b0;
      #1;
      if (stalled)
        chk(wr_valid_o && wr_data_o == pd && wr_slot_o == ps && wr_bank_o == pb,
            "R9 hold under stall", wr_data_o, pd);
      stalled = 1'b0;
      chk(!done_o, "R10 no early done", 32'(done_o), 0);
      if (wr_valid_o) begin
        if (wr_ready_i) begin
          int es = ch ? k / 2 : k;
          logic eb = ch ? 1'(k % 2) : 1'b0;
          logic [31:0] ed = base | (stamp ? (32'(es * 2) << 29) : 32'h0);
          chk(wr_slot_o == 3'(es), {req, " R5 slot order"}, 32'(wr_slot_o), 32'(es));
          chk(wr_bank_o == eb, {req, " R7 bank order"}, 32'(wr_bank_o), 32'(eb));
          chk(wr_data_o == ed, {req, " R1 R2 R3 R4 R6 word"}, wr_data_o, ed);
          k++;
        end else begin
          stalled = 1'b1; pd = wr_data_o; ps = wr_slot_o; pb = wr_bank_o;
        end
      end
      guard++;
      if (k < total) @(negedge clk);
    end
    wr_ready_i = 1'b1;
    chk(k == total, {req, " R5 write count"}, 32'(k), 32'(total));
    @(negedge clk); #1;
    chk(done_o && !wr_valid_o, {req, " R10 done after last write"}, 32'(done_o), 1);
    @(negedge clk); #1;
    chk(!done_o && !busy_o, {req, " R10 done single cycle"}, 32'(done_o), 0);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !wr_valid_o && !done_o, "R10 reset state", 32'({busy_o, wr_valid_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy_o && !wr_valid_o && !done_o, "R10 idle after reset", 32'({busy_o, wr_valid_o, done_o}), 0);

    // Table walk: R1..R7, R10.
    for (int v = 0; v < 7; v++) begin
      int ns;
      apply(VECS[v]);
      ns = ((1 << VECS[v].sel) < 4) ? (1 << VECS[v].sel) : 4;
      pulse_start();
      collect(VECS[v].base, VECS[v].mode == 3'd3, ns, VECS[v].ch, 1'b0, 1'b0,
              $sformatf("vec%0d", v));
    end

    // R9: stalled run, 3GB with two slots.
    apply(VECS[2]);
    pulse_start();
    collect(VECS[2].base, 1'b1, 2, 1'b0, 1'b1, 1'b0, "R9 stall");

    // R11: start and config changes during a run are ignored.
    apply(VECS[3]);
    pulse_start();
    collect(VECS[3].base, 1'b0, 4, 1'b0, 1'b0, 1'b1, "R11 disturb");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!busy_o && !wr_valid_o, "R11 ignored start left idle", 32'(busy_o), 0);
    end

    // R8: clear in 3GB mode, luma only, then with chroma.
    apply(VECS[2]);
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    collect(32'h0, 1'b0, 8, 1'b0, 1'b0, 1'b0, "R8 clear luma");
    apply(VECS[6]);
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    collect(32'h0, 1'b0, 8, 1'b1, 1'b0, 1'b0, "R8 clear both");

    // R8: clear wins over a simultaneous start.
    apply(VECS[0]);
    @(negedge clk); clear_i = 1'b1; start_i = 1'b1;
    @(negedge clk); clear_i = 1'b0; start_i = 1'b0;
    collect(32'h0, 1'b0, 8, 1'b0, 1'b1, 1'b0, "R8 clear beats start");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule